// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-visible register file of an I/O interrupt router. Software reaches all of its state through two bus offsets: a select register that picks an internal register, and a data window that reads or writes whichever internal register the select value names. Behind the window sit an identification register, a read-only version word and one 64-bit routing entry per interrupt input pin. Each entry occupies two consecutive select values, with the even value for the low word and the odd value for the high word.

The block stores the routing table and drives every field of every entry in parallel to the interrupt delivery logic: vector, delivery mode, destination mode, trigger mode, mask and destination. The delivery logic reports back through one set pulse per pin that raises the pin's remote-pending status bit. A software write to the low word of an entry clears that bit. When a write flips an entry's mask bit, the block raises a one-cycle notification for that pin.

The bus port takes one access per cycle and has no back-pressure, so it carries no ready signal. The block accepts an access whenever `acc_en` is high. A read returns its word with `rd_valid` in the following cycle. Writes take effect at the clock edge that accepts them.

Top module: `irq_route_regs`

## Requirements
- R1: A write to bus offset 0x00 stores the low 8 bits of the write data as the select value. A read of offset 0x00 returns the select value in bits 7:0, with zeros above.
- R2: A window read (bus offset 0x10) with select 0x01 returns the pin count minus one in bits 23:16 and the version code (0x20 by default) in bits 7:0, with all other bits zero. A window write with select 0x01 changes nothing.
- R3: A window write with select 0x00 stores write-data bits 27:24 as a 4-bit ID. A window read with select 0x00 or 0x02 returns the ID in bits 27:24 and zeros elsewhere. A window write with select 0x02 changes nothing.
- R4: For a select value of 0x10 or above, the entry index is (select - 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. A written word reads back unchanged, except for bit 14 of the low word. The entry layout is vector 7:0, delivery mode 10:8, destination mode 11, remote-pending 14, trigger mode 15 (1 = level), mask 16 and destination 63:56, and each field is driven on its output port.
- R5: A window read with an entry index at or beyond the pin count returns 0xFFFFFFFF. So does a window read with a select in 0x03..0x0F. A window write to any of these selects changes no entry, no output and the ID.
- R6: A pulse on `rirr_set[i]` sets the remote-pending bit of entry i. Any low-word write to entry i clears that bit, whatever the value of data bit 14, and the clear wins over a set pulse in the same cycle. A high-word write leaves the bit unchanged.
- R7: When a window write changes an entry's mask bit, `mask_chg` for that pin is high for exactly the one cycle after the write. It stays low when a write leaves the mask bit unchanged.
- R8: After reset every entry reads as zero except its mask bit, which is 1. The select value, the ID and all remote-pending bits are zero.
- R9: A read of any bus offset other than 0x00 and 0x10 returns zero. A write to such an offset changes no state.
- R10: `rd_valid` is high in exactly the cycle after a read access is accepted, with the word in `rd_data`. It is low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Bus offset |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read word valid (the cycle after a read) |
| rd_data | output | 32 | Read word |
| rirr_set | input | PINS | Per-pin remote-pending set pulses from the delivery logic |
| ent_vector | output | PINS x 8 | Vector field of each entry |
| ent_dlv_mode | output | PINS x 3 | Delivery mode field of each entry |
| ent_dst_mode | output | PINS | Destination mode bit of each entry |
| ent_remote | output | PINS | Remote-pending status bit of each entry |
| ent_level | output | PINS | Trigger mode bit of each entry (1 = level) |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_dest | output | PINS x 8 | Destination field of each entry |
| mask_chg | output | PINS | One-cycle pulse when a write changes the entry's mask bit |

## Verification
The hardest case to reach from the ports is a set pulse from the delivery logic that lands in the same cycle as a software low-word write to the same entry. The bench drives `rirr_set` together with the window write in one cycle, and it also fires set pulses at random between bus accesses. Select values at the edge of the decode are hard to hit at random, so they are covered directly. These are the last valid entry, the first index past the table and the unmapped gap below 0x10. The random selects are drawn from a range that spills past the table, so out-of-range reads and writes keep occurring throughout the random phase.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // bus offsets
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  // select values
  localparam logic [7:0] SEL_IDENT   = 8'h00;
  localparam logic [7:0] SEL_VERSION = 8'h01;
  localparam logic [7:0] SEL_ARBIT   = 8'h02;
  localparam logic [7:0] SEL_ENTRY0  = 8'h10;

  // entry field positions
  localparam int VEC_LO  = 0;
  localparam int VEC_HI  = 7;
  localparam int DLV_LO  = 8;
  localparam int DLV_HI  = 10;
  localparam int DSTM_B  = 11;
  localparam int RIRR_B  = 14;
  localparam int TRIG_B  = 15;
  localparam int MASK_B  = 16;
  localparam int DEST_LO = 56;
  localparam int DEST_HI = 63;

  // ID position in the identification word
  localparam int ID_LO = 24;
  localparam int ID_HI = 27;

  typedef enum logic [2:0] {
    K_IDENT,
    K_VERSION,
    K_ARBIT,
    K_ENTRY,
    K_NONE
  } sel_kind_e;

endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
  import irq_route_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic [7:0]       sel,
  output sel_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);

  localparam logic [6:0] PINS_LIM = 7'(PINS);

  logic [7:0] offs;
  logic [6:0] raw_idx;
  logic       in_table;

  assign offs     = sel - SEL_ENTRY0;
  assign raw_idx  = offs[7:1];
  assign in_table = (sel >= SEL_ENTRY0) && (raw_idx < PINS_LIM);
  assign idx      = raw_idx[IDX_W-1:0];
  assign hi       = sel[0];

  always_comb begin
    if (sel == SEL_IDENT)        kind = K_IDENT;
    else if (sel == SEL_VERSION) kind = K_VERSION;
    else if (sel == SEL_ARBIT)   kind = K_ARBIT;
    else if (in_table)           kind = K_ENTRY;
    else                         kind = K_NONE;
  end

endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  output logic [63:0] ent,
  output logic        mask_chg
);

  localparam logic [63:0] ENT_RST = 64'(1) << MASK_B;

  logic [63:0] ent_q;
  logic        chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= ENT_RST;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (rirr_set)
        ent_q[RIRR_B] <= 1'b1;
      if (wr_lo) begin
        // a software low-word write always drops the remote-pending bit
        ent_q[31:0]          <= wdata;
        ent_q[RIRR_B]        <= 1'b0;
        chg_q                <= wdata[MASK_B] ^ ent_q[MASK_B];
      end else if (wr_hi) begin
        ent_q[63:32] <= wdata;
      end
    end
  end

  assign ent      = ent_q;
  assign mask_chg = chg_q;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_route_pkg::*;
#(
  parameter int          PINS       = 24,
  parameter logic [7:0]  VERSION_ID = 8'h20,
  parameter int          IDX_W      = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic [7:0]             addr,
  input  logic [7:0]             sel,
  input  sel_kind_e              kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   hi,
  input  logic [3:0]             ident,
  input  logic [PINS-1:0][63:0]  ents,
  output logic [31:0]            word
);

  localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

  logic [31:0] win_word;
  logic [63:0] cur_ent;

  assign cur_ent = ents[idx];

  always_comb begin
    unique case (kind)
      K_IDENT, K_ARBIT: win_word = {4'd0, ident, 24'd0};
      K_VERSION:        win_word = {8'd0, MAX_PIN, 8'd0, VERSION_ID};
      K_ENTRY:          win_word = hi ? cur_ent[63:32] : cur_ent[31:0];
      default:          win_word = '1;
    endcase
  end

  always_comb begin
    if (addr == OFS_SELECT)      word = {24'd0, sel};
    else if (addr == OFS_WINDOW) word = win_word;
    else                         word = '0;
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         PINS       = 24,
  parameter logic [7:0] VERSION_ID = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic                  acc_wr,
  input  logic [7:0]            acc_addr,
  input  logic [31:0]           acc_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  input  logic [PINS-1:0]       rirr_set,
  output logic [PINS-1:0][7:0]  ent_vector,
  output logic [PINS-1:0][2:0]  ent_dlv_mode,
  output logic [PINS-1:0]       ent_dst_mode,
  output logic [PINS-1:0]       ent_remote,
  output logic [PINS-1:0]       ent_level,
  output logic [PINS-1:0]       ent_mask,
  output logic [PINS-1:0][7:0]  ent_dest,
  output logic [PINS-1:0]       mask_chg
);

  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1;

  logic [7:0]            sel_q;
  logic [3:0]            ident_q;
  logic                  rvalid_q;
  logic [31:0]           rdata_q;
  sel_kind_e             kind;
  logic [IDX_W-1:0]      idx;
  logic                  hi;
  logic                  wr_sel;
  logic                  wr_win;
  logic                  rd_acc;
  logic [PINS-1:0][63:0] ents;
  logic [31:0]           rd_word;

  assign wr_sel = acc_en && acc_wr && (acc_addr == OFS_SELECT);
  assign wr_win = acc_en && acc_wr && (acc_addr == OFS_WINDOW);
  assign rd_acc = acc_en && !acc_wr;

  irq_sel_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_dec (
    .sel  (sel_q),
    .kind (kind),
    .idx  (idx),
    .hi   (hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (wr_sel)
        sel_q <= acc_wdata[7:0];
      if (wr_win && kind == K_IDENT)
        ident_q <= acc_wdata[ID_HI:ID_LO];
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic hit;
    assign hit = wr_win && (kind == K_ENTRY) && (idx == IDX_W'(p));

    irq_redir_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (hit && !hi),
      .wr_hi    (hit && hi),
      .wdata    (acc_wdata),
      .rirr_set (rirr_set[p]),
      .ent      (ents[p]),
      .mask_chg (mask_chg[p])
    );

    assign ent_vector[p]   = ents[p][VEC_HI:VEC_LO];
    assign ent_dlv_mode[p] = ents[p][DLV_HI:DLV_LO];
    assign ent_dst_mode[p] = ents[p][DSTM_B];
    assign ent_remote[p]   = ents[p][RIRR_B];
    assign ent_level[p]    = ents[p][TRIG_B];
    assign ent_mask[p]     = ents[p][MASK_B];
    assign ent_dest[p]     = ents[p][DEST_HI:DEST_LO];
  end

  irq_read_mux #(.PINS(PINS), .VERSION_ID(VERSION_ID), .IDX_W(IDX_W)) u_rmux (
    .addr  (acc_addr),
    .sel   (sel_q),
    .kind  (kind),
    .idx   (idx),
    .hi    (hi),
    .ident (ident_q),
    .ents  (ents),
    .word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc)
        rdata_q <= rd_word;
    end
  end

  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int PINS = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_en,
  input logic                 acc_wr,
  input logic [7:0]           acc_addr,
  input logic                 rd_valid,
  input logic [31:0]          rd_data,
  input logic [PINS-1:0]      rirr_set,
  input logic [PINS-1:0][7:0] ent_vector,
  input logic [PINS-1:0]      ent_remote,
  input logic [PINS-1:0]      ent_mask,
  input logic [PINS-1:0][7:0] ent_dest,
  input logic [PINS-1:0]      mask_chg
);

  assert_sel_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr == 8'h00) |=> (rd_data[31:8] == 24'd0));

  assert_rvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rd_valid);

  assert_rvalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rd_valid);

  assert_mask_pulse_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg == (ent_mask ^ $past(ent_mask)));

  assert_mask_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_chg != '0) |-> $past(acc_en && acc_wr && acc_addr == 8'h10));

  assert_mask_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_chg) <= 1);

  assert_other_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr != 8'h00 && acc_addr != 8'h10 && rirr_set == '0)
    |=> ($stable(ent_vector) && $stable(ent_mask) && $stable(ent_dest) && $stable(ent_remote)));

  assert_rirr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set != '0 && !(acc_en && acc_wr)) |=> ((ent_remote & $past(rirr_set)) == $past(rirr_set)));

endmodule

bind irq_route_regs irq_route_regs_chk #(.PINS(PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .rirr_set   (rirr_set),
  .ent_vector (ent_vector),
  .ent_remote (ent_remote),
  .ent_mask   (ent_mask),
  .ent_dest   (ent_dest),
  .mask_chg   (mask_chg)
);

// File: tb/sim_irq_route_regs.sv
`timescale 1ns/1ps
module sim_irq_route_regs;

  localparam int         PINS = 24;
  localparam logic [7:0] VER  = 8'h20;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  acc_en = 1'b0;
  logic                  acc_wr = 1'b0;
  logic [7:0]            acc_addr = '0;
  logic [31:0]           acc_wdata = '0;
  logic                  rd_valid;
  logic [31:0]           rd_data;
  logic [PINS-1:0]       rirr_set = '0;
  logic [PINS-1:0][7:0]  ent_vector;
  logic [PINS-1:0][2:0]  ent_dlv_mode;
  logic [PINS-1:0]       ent_dst_mode;
  logic [PINS-1:0]       ent_remote;
  logic [PINS-1:0]       ent_level;
  logic [PINS-1:0]       ent_mask;
  logic [PINS-1:0][7:0]  ent_dest;
  logic [PINS-1:0]       mask_chg;

  always #10 clk = ~clk;

  irq_route_regs #(.PINS(PINS), .VERSION_ID(VER)) u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_ent [PINS];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_window(input logic [7:0] s);
    int ix;
    if (s == 8'h00 || s == 8'h02) return {4'd0, m_id, 24'd0};
    if (s == 8'h01) return {8'd0, 8'(PINS - 1), 8'd0, VER};
    if (s < 8'h10) return 32'hFFFF_FFFF;
    ix = (int'(s) - 16) >> 1;
    if (ix >= PINS) return 32'hFFFF_FFFF;
    return s[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {24'd0, m_sel};
    if (a == 8'h10) return exp_window(m_sel);
    return 32'd0;
  endfunction

  task automatic check_pin(input string req, input int p);
    check(req, ent_vector[p],   m_ent[p][7:0]);
    check(req, ent_dlv_mode[p], m_ent[p][10:8]);
    check(req, ent_dst_mode[p], m_ent[p][11]);
    check(req, ent_remote[p],   m_ent[p][14]);
    check(req, ent_level[p],    m_ent[p][15]);
    check(req, ent_mask[p],     m_ent[p][16]);
    check(req, ent_dest[p],     m_ent[p][63:56]);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < PINS; p++) check_pin(req, p);
  endtask

  // caller is just after a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [PINS-1:0] rs);
    logic [PINS-1:0] exp_chg;
    int ix;
    exp_chg = '0;
    for (int p = 0; p < PINS; p++) if (rs[p]) m_ent[p][14] = 1'b1;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[27:24];
      else if (m_sel >= 8'h10) begin
        ix = (int'(m_sel) - 16) >> 1;
        if (ix < PINS) begin
          if (m_sel[0]) m_ent[ix][63:32] = d;
          else begin
            exp_chg[ix] = m_ent[ix][16] ^ d[16];
            m_ent[ix][31:0] = d;
            m_ent[ix][14] = 1'b0;
          end
        end
      end
    end
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d; rirr_set = rs;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; rirr_set = '0;
    check("R7 mask_chg", mask_chg, exp_chg);
    check("R10 rd_valid after write", rd_valid, 1'b0);
  endtask

  task automatic bus_read(input string req, input logic [7:0] a);
    logic [31:0] e;
    e = exp_read(a);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0;
    check("R10 rd_valid", rd_valid, 1'b1);
    check(req, rd_data, e);
  endtask

  task automatic pulse_rirr(input logic [PINS-1:0] rs);
    for (int p = 0; p < PINS; p++) if (rs[p]) m_ent[p][14] = 1'b1;
    rirr_set = rs;
    @(posedge clk);
    @(negedge clk);
    rirr_set = '0;
    check("R6 remote after set", ent_remote, {<<{ {<<{rs}} }} | ent_remote_model());
  endtask

  function automatic logic [PINS-1:0] ent_remote_model();
    logic [PINS-1:0] r;
    for (int p = 0; p < PINS; p++) r[p] = m_ent[p][14];
    return r;
  endfunction

  function automatic logic [7:0] rand_sel();
    int k;
    k = $urandom_range(0, 9);
    if (k == 0) return 8'($urandom_range(0, 2));
    if (k == 1) return 8'($urandom_range(3, 15));
    return 8'($urandom_range(16, 16 + 2 * PINS + 7));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < PINS; p++) m_ent[p] = 64'h0000_0000_0001_0000;
    m_sel = '0;
    m_id  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    check("R8 mask after reset", ent_mask, {PINS{1'b1}});
    check("R8 remote after reset", ent_remote, {PINS{1'b0}});
    check("R8 rd_valid after reset", rd_valid, 1'b0);
    check_all("R8 fields after reset");
    bus_read("R8 select after reset", 8'h00);
    bus_read("R8 id after reset", 8'h10);
    bus_write(8'h00, 32'h0000_0010, '0);
    bus_read("R8 entry0 low after reset", 8'h10);

    // R1: select keeps low 8 bits
    bus_write(8'h00, 32'hABCD_12F3, '0);
    bus_read("R1 select readback", 8'h00);
    check("R1 select value", rd_data, 32'h0000_00F3);

    // R2: version word, write ignored
    bus_write(8'h00, 32'h1, '0);
    bus_read("R2 version", 8'h10);
    check("R2 version value", rd_data, 32'h0017_0020);
    bus_write(8'h10, 32'hFFFF_FFFF, '0);
    bus_read("R2 version after write", 8'h10);

    // R3: ID store, arbitration alias, arbitration write ignored
    bus_write(8'h00, 32'h0, '0);
    bus_write(8'h10, 32'hF7FF_FFFF, '0);
    bus_read("R3 id readback", 8'h10);
    check("R3 id value", rd_data, 32'h0700_0000);
    bus_write(8'h00, 32'h2, '0);
    bus_read("R3 arb readback", 8'h10);
    bus_write(8'h10, 32'h0A00_0000, '0);
    bus_write(8'h00, 32'h0, '0);
    bus_read("R3 id after arb write", 8'h10);

    // R4/R7: entry 5 halves
    bus_write(8'h00, 32'h1A, '0);
    bus_write(8'h10, 32'h0001_89AB, '0);   // mask stays 1: no pulse
    bus_write(8'h10, 32'h0000_A931, '0);   // mask 1 -> 0: pulse
    bus_write(8'h00, 32'h1B, '0);
    bus_write(8'h10, 32'hC300_0000, '0);
    check_pin("R4 entry5 fields", 5);
    check("R4 entry5 dest", ent_dest[5], 8'hC3);
    bus_read("R4 entry5 high", 8'h10);
    bus_write(8'h00, 32'h1A, '0);
    bus_read("R4 entry5 low", 8'h10);
    // last valid entry
    bus_write(8'h00, 32'h10 + 2 * (PINS - 1), '0);
    bus_write(8'h10, 32'h0000_80FE, '0);
    check_pin("R4 last entry fields", PINS - 1);

    // R6: remote-pending set/clear
    pulse_rirr(24'h00_0020);
    bus_write(8'h00, 32'h1A, '0);
    bus_read("R6 remote visible in low word", 8'h10);
    bus_write(8'h00, 32'h1B, '0);
    bus_write(8'h10, 32'h1100_0000, '0);
    check("R6 remote kept by high write", ent_remote[5], 1'b1);
    bus_write(8'h00, 32'h1A, '0);
    bus_write(8'h10, 32'h0000_4031, '0);  // data bit14 set, still cleared
    check("R6 remote cleared by low write", ent_remote[5], 1'b0);
    bus_write(8'h10, 32'h0000_0031, 24'h00_0020);  // same-cycle set and clear
    check("R6 clear wins over set", ent_remote[5], 1'b0);

    // R5: out-of-range selects
    bus_write(8'h00, 32'h10 + 2 * PINS, '0);
    bus_read("R5 first index past table", 8'h10);
    bus_write(8'h10, 32'h0000_00FF, '0);
    check_all("R5 write past table inert");
    bus_write(8'h00, 32'h4F, '0);
    bus_read("R5 high out-of-range", 8'h10);
    bus_write(8'h00, 32'h05, '0);
    bus_read("R5 gap select", 8'h10);
    bus_write(8'h10, 32'hFFFF_FFFF, '0);
    check_all("R5 gap write inert");
    bus_write(8'h00, 32'h0, '0);
    bus_read("R5 id after gap write", 8'h10);

    // R9: other offsets
    bus_read("R9 offset 04", 8'h04);
    bus_read("R9 offset 20", 8'h20);
    bus_read("R9 offset FF", 8'hFF);
    bus_write(8'h20, 32'h0000_0033, '0);
    bus_write(8'h14, 32'hFFFF_FFFF, '0);
    bus_read("R9 select after stray writes", 8'h00);
    check_all("R9 entries after stray writes");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 1) bus_write(8'h00, {24'($urandom), rand_sel()}, '0);
      else if (op <= 4) bus_write(8'h10, $urandom, '0);
      else if (op <= 6) bus_read("R4 random window read", 8'h10);
      else if (op == 7) pulse_rirr(PINS'(1) << $urandom_range(0, PINS - 1));
      else if (op == 8) bus_read("R1 random select read", 8'h00);
      else bus_read("R9 random other read", 8'($urandom_range(1, 15)));
    end
    check_all("R4 fields after random");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule